// File: doc/BRIEF.md
# Pixel Rectangle Copy Engine with RGBA-to-RGB Packing

This block moves a rectangle of pixels from one framebuffer in byte-addressed memory to another. Along the way it converts each 4-byte RGBA source pixel into a 3-byte packed RGB destination pixel. The engine has a small register file written through a simple write port. That file holds the source and destination base addresses, the source row width, the output width and height, the format codes and a horizontal decimation flag. Writing a one into bit 0 of the trigger register launches the copy.

The engine walks the output rectangle row by row and, inside each row, pixel by pixel. For every pixel it reads the three colour bytes from the source, one per cycle, on a byte-wide read port with one cycle of latency. It writes each byte to the destination on the following cycle. The alpha byte is never fetched. With decimation enabled, every second source pixel is skipped, and the source row pitch doubles to match. Format codes the engine cannot handle raise a sticky error flag. An unknown source format gives zero-filled output. An unknown destination format gives no output at all. A one-cycle done pulse marks the end of every accepted launch.

Top module: `fbx_top`

## Requirements
- R1: A transfer starts only on a register write to index 6 (trigger) whose bit 0 is 1. A trigger write with bit 0 clear has no effect.
- R2: A trigger write that arrives while busy is high is ignored. Configuration writes made during a transfer do not change that transfer, because its parameters are captured at launch.
- R3: Output pixels are produced row by row, and left to right within a row. Destination byte b of pixel (x, y) is at dst_base + 3·x + 3·out_width·y + b, so the writes form one ascending run of addresses.
- R4: Source byte b of output pixel (x, y) is read from src_base + 4·k·x + 4·k·in_width·y + b. Here k is 2 when the mode register's scale bit (bit 8) is set, and 1 otherwise.
- R5: Bytes 0, 1 and 2 of each source pixel go to bytes 0, 1 and 2 of the destination pixel. The source alpha byte is neither read nor written, so a transfer makes exactly 3·W·H reads and 3·W·H writes, and nothing lies beyond the rectangle.
- R6: The mode register (index 5) holds the input format in bits 2:0 and the output format in bits 6:4. Code 0 (4-byte RGBA) is the only valid input format, and code 1 (3-byte RGB) is the only valid output format. The other indices are 0 source base, 1 destination base, 2 input width, 3 output width and 4 output height.
- R7: On launch with an invalid input format, err is set, no reads are issued, and every destination byte of the rectangle is written with zero.
- R8: On launch with an invalid output format, err is set and no reads or writes are made, but done still pulses.
- R9: done is a one-cycle pulse that is high during cycle 3·N+1 after the clock edge that accepted the trigger, where N is the number of pixels written. busy is high from that edge until the cycle after done.
- R10: A launch with output width 0 or output height 0 makes no memory access and pulses done in cycle 1 after the trigger edge.
- R11: After reset, busy, done, err, rd_en and wr_en are low. Once set, err stays set until reset.
- R12: The read port returns rd_data in the cycle after rd_en, and every read is followed in the next cycle by the matching write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | CW | Register write data |
| rd_en | output | 1 | Source byte read request |
| rd_addr | output | AW | Source byte address |
| rd_data | input | 8 | Source byte, valid the cycle after rd_en |
| wr_en | output | 1 | Destination byte write strobe |
| wr_addr | output | AW | Destination byte address |
| wr_data | output | 8 | Destination byte |
| busy | output | 1 | Transfer in progress (trigger bit) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky unsupported-format flag |

## Verification
The bench sweeps small rectangles, with and without decimation, and uses a source row width that differs from the output width. A wrong row pitch or a missing doubling would then land bytes from the wrong source row or column, and those bytes show up as content mismatches. Each run also checks the cycle on which done arrives, the exact read and write counts, and sentinel bytes just past the rectangle. These catch an engine that fetches or stores alpha, stops one pixel early or runs one pixel long. It retriggers mid-transfer after changing the destination base. A design that accepted the second trigger, or that used live register values, would pulse done twice or write into the alternate region. Zero-sized and bad-format launches confirm that done still arrives without memory traffic, that zeros are written for a bad source format, and that err survives a later good transfer until reset.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  // register indices on the configuration write port
  localparam logic [2:0] IDX_SRC  = 3'd0;
  localparam logic [2:0] IDX_DST  = 3'd1;
  localparam logic [2:0] IDX_IW   = 3'd2;
  localparam logic [2:0] IDX_OW   = 3'd3;
  localparam logic [2:0] IDX_OH   = 3'd4;
  localparam logic [2:0] IDX_MODE = 3'd5;
  localparam logic [2:0] IDX_TRIG = 3'd6;

  // format codes
  localparam logic [2:0] FMT_RGBA8 = 3'd0;
  localparam logic [2:0] FMT_RGB8  = 3'd1;

  // mode register field positions
  localparam int MODE_IFMT_LSB = 0;
  localparam int MODE_OFMT_LSB = 4;
  localparam int MODE_SCALE    = 8;

  // bytes moved per output pixel
  localparam int OUT_BYTES = 3;
endpackage

// File: rtl/fbx_regs.sv
module fbx_regs
  import fbx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 12,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    idx,
  input  logic [CW-1:0] wdata,
  input  logic          fin,
  output logic [AW-1:0] src_base,
  output logic [AW-1:0] dst_base,
  output logic [DW-1:0] in_w,
  output logic [DW-1:0] out_w,
  output logic [DW-1:0] out_h,
  output logic          scale,
  output logic          in_ok,
  output logic          out_ok,
  output logic          start,
  output logic          busy,
  output logic          err
);
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] iw_q, ow_q, oh_q;
  logic [2:0]    ifmt_q, ofmt_q;
  logic          scale_q, busy_q, err_q;
  logic          busy_d, err_d;
  logic          en_src, en_dst, en_iw, en_ow, en_oh, en_mode;

  // write enables per field
  always_comb begin
    en_src  = we && (idx == IDX_SRC);
    en_dst  = we && (idx == IDX_DST);
    en_iw   = we && (idx == IDX_IW);
    en_ow   = we && (idx == IDX_OW);
    en_oh   = we && (idx == IDX_OH);
    en_mode = we && (idx == IDX_MODE);
  end

  always_comb begin
    in_ok  = (ifmt_q == FMT_RGBA8);
    out_ok = (ofmt_q == FMT_RGB8);
    start  = we && (idx == IDX_TRIG) && wdata[0] && !busy_q;
    busy_d = start | (busy_q & ~fin);
    err_d  = err_q | (start & ~(in_ok & out_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (en_src) src_q <= wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q <= '0;
    else if (en_dst) dst_q <= wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     iw_q <= '0;
    else if (en_iw) iw_q <= wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ow_q <= '0;
    else if (en_ow) ow_q <= wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     oh_q <= '0;
    else if (en_oh) oh_q <= wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifmt_q  <= FMT_RGBA8;
      ofmt_q  <= FMT_RGB8;
      scale_q <= 1'b0;
    end else if (en_mode) begin
      ifmt_q  <= wdata[MODE_IFMT_LSB +: 3];
      ofmt_q  <= wdata[MODE_OFMT_LSB +: 3];
      scale_q <= wdata[MODE_SCALE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  assign src_base = src_q;
  assign dst_base = dst_q;
  assign in_w     = iw_q;
  assign out_w    = ow_q;
  assign out_h    = oh_q;
  assign scale    = scale_q;
  assign busy     = busy_q;
  assign err      = err_q;
endmodule

// File: rtl/fbx_walker.sv
module fbx_walker
  import fbx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [DW-1:0] in_w,
  input  logic [DW-1:0] out_w,
  input  logic [DW-1:0] out_h,
  input  logic          scale,
  input  logic          in_ok,
  input  logic          out_ok,
  output logic          iss_valid,
  output logic          iss_last,
  output logic          iss_zero,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          empty_fin
);
  localparam int          PAD      = AW - DW;
  localparam logic [1:0]  LAST_B   = 2'(OUT_BYTES - 1);
  localparam logic [AW-1:0] DSTEP  = AW'(OUT_BYTES);

  logic          act_q, act_d;
  logic          zero_q, zero_d;
  logic [1:0]    b_q, b_d;
  logic [DW-1:0] x_q, x_d, y_q, y_d, ow_q, ow_d, oh_q, oh_d;
  logic [AW-1:0] srow_q, srow_d, drow_q, drow_d;
  logic [AW-1:0] sptr_q, sptr_d, dptr_q, dptr_d;
  logic [AW-1:0] pstep_q, pstep_d, rstep_q, rstep_d, drstep_q, drstep_d;
  logic          empty_q, empty_d;
  logic          adv_en, go, end_col, end_row;
  logic [AW-1:0] ow_ext, iw_ext;

  always_comb begin
    ow_ext  = {{PAD{1'b0}}, out_w};
    iw_ext  = {{PAD{1'b0}}, in_w};
    go      = out_ok && (out_w != '0) && (out_h != '0);
    end_col = (x_q == ow_q - DW'(1));
    end_row = (y_q == oh_q - DW'(1));
    adv_en  = start | act_q;
  end

  // next-state logic
  always_comb begin
    act_d    = act_q;
    zero_d   = zero_q;
    b_d      = b_q;
    x_d      = x_q;
    y_d      = y_q;
    ow_d     = ow_q;
    oh_d     = oh_q;
    srow_d   = srow_q;
    drow_d   = drow_q;
    sptr_d   = sptr_q;
    dptr_d   = dptr_q;
    pstep_d  = pstep_q;
    rstep_d  = rstep_q;
    drstep_d = drstep_q;
    empty_d  = 1'b0;
    if (start) begin
      act_d    = go;
      empty_d  = !go;
      zero_d   = !in_ok;
      b_d      = '0;
      x_d      = '0;
      y_d      = '0;
      ow_d     = out_w;
      oh_d     = out_h;
      srow_d   = src_base;
      drow_d   = dst_base;
      sptr_d   = src_base;
      dptr_d   = dst_base;
      pstep_d  = scale ? AW'(8) : AW'(4);
      rstep_d  = scale ? (iw_ext << 3) : (iw_ext << 2);
      drstep_d = (ow_ext << 1) + ow_ext;
    end else if (act_q) begin
      if (b_q != LAST_B) begin
        b_d = b_q + 2'd1;
      end else begin
        b_d = '0;
        if (end_col) begin
          x_d = '0;
          if (end_row) begin
            act_d = 1'b0;
          end else begin
            y_d    = y_q + DW'(1);
            srow_d = srow_q + rstep_q;
            drow_d = drow_q + drstep_q;
            sptr_d = srow_q + rstep_q;
            dptr_d = drow_q + drstep_q;
          end
        end else begin
          x_d    = x_q + DW'(1);
          sptr_d = sptr_q + pstep_q;
          dptr_d = dptr_q + DSTEP;
        end
      end
    end
  end

  // state registers with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      zero_q   <= 1'b0;
      b_q      <= '0;
      x_q      <= '0;
      y_q      <= '0;
      ow_q     <= '0;
      oh_q     <= '0;
      srow_q   <= '0;
      drow_q   <= '0;
      sptr_q   <= '0;
      dptr_q   <= '0;
      pstep_q  <= '0;
      rstep_q  <= '0;
      drstep_q <= '0;
    end else if (adv_en) begin
      act_q    <= act_d;
      zero_q   <= zero_d;
      b_q      <= b_d;
      x_q      <= x_d;
      y_q      <= y_d;
      ow_q     <= ow_d;
      oh_q     <= oh_d;
      srow_q   <= srow_d;
      drow_q   <= drow_d;
      sptr_q   <= sptr_d;
      dptr_q   <= dptr_d;
      pstep_q  <= pstep_d;
      rstep_q  <= rstep_d;
      drstep_q <= drstep_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= 1'b0;
    else        empty_q <= empty_d;
  end

  always_comb begin
    iss_valid = act_q;
    iss_last  = act_q && (b_q == LAST_B) && end_col && end_row;
    iss_zero  = zero_q;
    src_addr  = sptr_q + {{(AW-2){1'b0}}, b_q};
    dst_addr  = dptr_q + {{(AW-2){1'b0}}, b_q};
    empty_fin = empty_q;
  end
endmodule

// File: rtl/fbx_sink.sv
module fbx_sink #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_last,
  input  logic          iss_zero,
  input  logic [AW-1:0] dst_addr,
  input  logic          empty_fin,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done
);
  logic          wv_q, wl_q, wz_q, done_q;
  logic          wv_d, wl_d, done_d;
  logic [AW-1:0] wa_q;

  always_comb begin
    wv_d   = iss_valid;
    wl_d   = iss_last;
    done_d = wl_q | empty_fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q   <= 1'b0;
      wl_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      wv_q   <= wv_d;
      wl_q   <= wl_d;
      done_q <= done_d;
    end
  end

  // address and fill flag follow the issued byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= '0;
      wz_q <= 1'b0;
    end else if (iss_valid) begin
      wa_q <= dst_addr;
      wz_q <= iss_zero;
    end
  end

  assign wr_en   = wv_q;
  assign wr_addr = wa_q;
  assign wr_data = wz_q ? 8'h00 : rd_data;
  assign done    = done_q;
endmodule

// File: rtl/fbx_top.sv
module fbx_top #(
  parameter int AW = 32,
  parameter int DW = 12,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [CW-1:0] cfg_wdata,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  logic          rs1_q, rs2_q;
  logic [AW-1:0] src_base, dst_base, src_addr, dst_addr;
  logic [DW-1:0] in_w, out_w, out_h;
  logic          scale, in_ok, out_ok, start;
  logic          iss_valid, iss_last, iss_zero, empty_fin;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  fbx_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rs2_q),
    .we       (cfg_we),
    .idx      (cfg_idx),
    .wdata    (cfg_wdata),
    .fin      (done),
    .src_base (src_base),
    .dst_base (dst_base),
    .in_w     (in_w),
    .out_w    (out_w),
    .out_h    (out_h),
    .scale    (scale),
    .in_ok    (in_ok),
    .out_ok   (out_ok),
    .start    (start),
    .busy     (busy),
    .err      (err)
  );

  fbx_walker #(.AW(AW), .DW(DW)) u_walk (
    .clk       (clk),
    .rst_n     (rs2_q),
    .start     (start),
    .src_base  (src_base),
    .dst_base  (dst_base),
    .in_w      (in_w),
    .out_w     (out_w),
    .out_h     (out_h),
    .scale     (scale),
    .in_ok     (in_ok),
    .out_ok    (out_ok),
    .iss_valid (iss_valid),
    .iss_last  (iss_last),
    .iss_zero  (iss_zero),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .empty_fin (empty_fin)
  );

  fbx_sink #(.AW(AW)) u_sink (
    .clk       (clk),
    .rst_n     (rs2_q),
    .iss_valid (iss_valid),
    .iss_last  (iss_last),
    .iss_zero  (iss_zero),
    .dst_addr  (dst_addr),
    .empty_fin (empty_fin),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (done)
  );

  assign rd_en   = iss_valid & ~iss_zero;
  assign rd_addr = src_addr;
endmodule

// File: rtl/fbx_checker.sv
module fbx_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          busy,
  input logic          done,
  input logic          err
);
  // R1: busy only rises after a register write
  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_we));

  // R3: consecutive writes form an ascending run
  p_wr_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1)));

  // R9: done lasts one cycle and busy drops right after it
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9: memory traffic only inside a transfer
  p_wr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  p_rd_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  // R11: sticky error
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R12: each read is followed by its write
  p_rd_then_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);
endmodule

bind fbx_top fbx_checker #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .busy    (busy),
  .done    (done),
  .err     (err)
);

// File: tb/sim_fbx_top.sv
`timescale 1ns/1ps
module sim_fbx_top;
  localparam int AW = 32;
  localparam int DW = 12;
  localparam int CW = 32;
  localparam int SRC0 = 32'h100;
  localparam int DST0 = 32'h1000;
  localparam int ALT0 = 32'h1800;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_idx;
  logic [CW-1:0] cfg_wdata;
  logic          rd_en, wr_en, busy, done, err;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;

  always #2.5 clk = ~clk;

  fbx_top #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, ord_err = 0;
  int seg_start = 0;
  bit exp_err = 1'b0;
  logic [7:0] dmem [0:8191];

  function automatic logic [7:0] src_byte(input logic [AW-1:0] a);
    return 8'((a * 13) + ((a >> 7) * 5) + 32'h21);
  endfunction

  // source memory model: one cycle latency
  always @(posedge clk) begin
    if (rd_en) rd_data <= src_byte(rd_addr);
  end

  // destination memory and traffic monitor
  always @(posedge clk) begin
    if (wr_en) begin
      dmem[wr_addr[12:0]] <= wr_data;
      if (wr_addr != AW'(DST0 + (wr_cnt - seg_start))) ord_err++;
      wr_cnt++;
    end
    if (rd_en) rd_cnt++;
    if (done)  done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgw(input logic [2:0] idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = CW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_err = 1'b0;
    chk(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R11 done after reset", int'(done), 0);
    chk(err == 1'b0, "R11 err after reset", int'(err), 0);
    chk(rd_en == 1'b0 && wr_en == 1'b0, "R11 ports idle after reset",
        int'(rd_en | wr_en), 0);
  endtask

  task automatic run(input int w, input int h, input int iw, input bit sc,
                     input int ifm, input int ofm, input bit poke);
    int n_exp, lat, rd_exp, w0, r0, d0, o0, cnt, k, idx;
    bit good, zf;
    logic [7:0] e;
    good   = (ofm == 1) && (w > 0) && (h > 0);
    zf     = (ifm != 0);
    n_exp  = good ? 3 * w * h : 0;
    lat    = n_exp + 1;
    rd_exp = (good && !zf) ? n_exp : 0;
    for (int i = 0; i < 512; i++) begin
      dmem[DST0 + i] = 8'hEE;
      dmem[ALT0 + i] = 8'hEE;
    end
    cfgw(3'd0, SRC0);
    cfgw(3'd1, DST0);
    cfgw(3'd2, iw);
    cfgw(3'd3, w);
    cfgw(3'd4, h);
    cfgw(3'd5, (int'(sc) << 8) | (ofm << 4) | ifm);
    seg_start = wr_cnt;
    w0 = wr_cnt; r0 = rd_cnt; d0 = done_cnt; o0 = ord_err;
    if (ifm != 0 || ofm != 1) exp_err = 1'b1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_wdata = 1;
    @(posedge clk);
    cnt = 0;
    @(negedge clk);
    cfg_we = 1'b0;
    while (!done && cnt < 4000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (poke && cnt == 4) begin
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_wdata = ALT0;
      end else if (poke && cnt == 5) begin
        cfg_we = 1'b1; cfg_idx = 3'd6; cfg_wdata = 1;
      end else begin
        cfg_we = 1'b0;
      end
    end
    cfg_we = 1'b0;
    chk(cnt == lat, "R9/R10 done cycle", cnt, lat);
    repeat (40) @(negedge clk);
    chk(done_cnt - d0 == 1, "R2/R9 done pulses", done_cnt - d0, 1);
    chk(wr_cnt - w0 == n_exp, "R5/R8 write count", wr_cnt - w0, n_exp);
    chk(rd_cnt - r0 == rd_exp, "R5/R7/R12 read count", rd_cnt - r0, rd_exp);
    chk(ord_err == o0, "R3 write order", ord_err - o0, 0);
    chk(busy == 1'b0, "R9 busy after done", int'(busy), 0);
    chk(err == exp_err, "R6/R7/R8/R11 err flag", int'(err), int'(exp_err));
    if (good) begin
      for (int y = 0; y < h; y++)
        for (int x = 0; x < w; x++)
          for (int b = 0; b < 3; b++) begin
            idx = 3 * (y * w + x) + b;
            k   = sc ? 2 : 1;
            e   = zf ? 8'h00 : src_byte(AW'(SRC0 + 4 * k * x + 4 * k * iw * y + b));
            chk(dmem[DST0 + idx] == e, zf ? "R7 zero fill" : "R4 source byte",
                int'(dmem[DST0 + idx]), int'(e));
          end
    end
    for (int j = 0; j < 6; j++)
      chk(dmem[DST0 + n_exp + j] == 8'hEE, "R5 nothing past rectangle",
          int'(dmem[DST0 + n_exp + j]), 8'hEE);
    if (poke)
      for (int j = 0; j < 32; j++)
        chk(dmem[ALT0 + j] == 8'hEE, "R2 retrigger ignored",
            int'(dmem[ALT0 + j]), 8'hEE);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0, r0;
    do_reset();

    // R1: trigger write with bit 0 clear does nothing
    cfgw(3'd0, SRC0);
    cfgw(3'd1, DST0);
    cfgw(3'd2, 2);
    cfgw(3'd3, 2);
    cfgw(3'd4, 2);
    cfgw(3'd5, 32'h10);
    w0 = wr_cnt; r0 = rd_cnt;
    cfgw(3'd6, 32'h2);
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R1 no start on bit0 clear", int'(busy), 0);
    chk((wr_cnt - w0) + (rd_cnt - r0) == 0, "R1 no traffic",
        (wr_cnt - w0) + (rd_cnt - r0), 0);

    // R3/R4/R5/R9: sweep small rectangles, both scale settings
    for (int sc = 0; sc < 2; sc++)
      for (int h = 1; h <= 3; h++)
        for (int w = 1; w <= 3; w++)
          run(w, h, w + 1, sc[0], 0, 1, 1'b0);

    // R2: retrigger and base change while busy
    run(3, 3, 3, 1'b0, 0, 1, 1'b1);

    // R10: empty rectangles
    run(0, 2, 2, 1'b0, 0, 1, 1'b0);
    run(2, 0, 2, 1'b1, 0, 1, 1'b0);

    // R7: unsupported input format, then R11 stickiness across a good run
    run(2, 2, 3, 1'b0, 2, 1, 1'b0);
    run(2, 1, 2, 1'b1, 0, 1, 1'b0);
    do_reset();

    // R8: unsupported output format
    run(2, 2, 2, 1'b0, 0, 0, 1'b0);
    do_reset();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule